// File: doc/BRIEF.md
# DDS Phase Accumulator Bank

This block produces the oscillator phases for one channel of a waveform generator. It holds three phase accumulators: two slow oscillators, each with a 48-bit frequency word, and one up-converter with a 32-bit frequency word. Each accumulator adds its frequency word on every clock edge, at the full clock rate. The top 16 bits of the accumulator plus a 16-bit phase offset form the output phase, in units of one turn.

A phase-update strobe loads a new phase offset. A per-accumulator clear bit selects what the strobe does to the accumulator. In absolute mode the strobe zeroes the accumulator, so the output phase becomes exactly the commanded phase. In relative mode the accumulator keeps running and the new phase only shifts it. The up-converter emits several phase samples per clock, one per lane.

Each accumulator tracks its update state with a two-state machine:
- `PH_RUN`: the accumulator advanced normally on the last edge.
- `PH_ZERO`: the last edge was an absolute strobe, which zeroed the accumulator.

The transitions are:
- `RUN->ZERO`: taken on an absolute strobe.
- `ZERO->ZERO`: taken on a second absolute strobe in a row.
- `ZERO->RUN` and `RUN->RUN`: taken on any other edge.

Top module: `dds_phase_bank`

## Requirements
- R1: A phase strobe on an accumulator whose clear bit is 1 zeroes that accumulator in place of the increment. On the following cycle its output phase (lane 0 for the up-converter) equals the commanded phase exactly.
- R2: A phase strobe on an accumulator whose clear bit is 0 leaves the accumulator advancing normally. The output becomes top16(accumulator) + phase, modulo 2^16.
- R3: `clr_mode_we` loads all three clear bits from `clr_mode_wdata`, with this layout: bit 0 is slow oscillator 1, bit 1 is slow oscillator 2, and bit 2 is the up-converter. Without the strobe the bits hold.
- R4: After reset, all three clear bits are 1, and every accumulator and phase offset is zero.
- R5: The slow frequency words are 48 bits wide and the up-converter word is 32 bits wide. The output phase is bits [W-1:W-16] of the accumulator plus the 16-bit offset, and it wraps modulo one turn.
- R6: Every accumulator advances on every clock edge that carries no absolute strobe. It advances by LANES times its frequency word, modulo 2^W, with no stall.
- R7: Up-converter lane k, at bits [16k+15:16k] of `dc_phase_out`, equals top16(acc + k*freq) + offset.
- R8: After an absolute strobe, the next cycle resumes from zero, so the accumulator equals LANES*freq. An absolute strobe on back-to-back cycles zeroes it again.
- R9: When a clear-mode write and a phase strobe fall on the same edge, the strobe uses the clear bits held before that edge.
- R10: The phase offset holds its value until the next strobe on that accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_mode_we | input | 1 | Clear-mode write strobe |
| clr_mode_wdata | input | 3 | Clear bits: [0] slow 1, [1] slow 2, [2] up-converter |
| dc_freq | input | 32 | Up-converter frequency word |
| dc_phase | input | 16 | Up-converter phase word |
| dc_phase_we | input | 1 | Up-converter phase strobe |
| s1_freq | input | 48 | Slow oscillator 1 frequency word |
| s1_phase | input | 16 | Slow oscillator 1 phase word |
| s1_phase_we | input | 1 | Slow oscillator 1 phase strobe |
| s2_freq | input | 48 | Slow oscillator 2 frequency word |
| s2_phase | input | 16 | Slow oscillator 2 phase word |
| s2_phase_we | input | 1 | Slow oscillator 2 phase strobe |
| dc_phase_out | output | 64 | Up-converter phases, 4 lanes of 16 bits, lane 0 lowest |
| s1_phase_out | output | 16 | Slow oscillator 1 phase |
| s2_phase_out | output | 16 | Slow oscillator 2 phase |

## Verification
The bench builds the block with its default parameters:
- four up-converter lanes;
- 48-bit slow frequency words;
- a 32-bit up-converter frequency word.

With four lanes, the per-lane offsets k*freq and the stride of four per cycle can both be seen. Frequency words of 1<<32 and 1<<16 put one count per step on the output phase, so expected values can be read directly.

Words such as 0xFFFF_0000_0000 and half-LSB fractions exercise wrap-around and carry from the hidden low bits. Writing the clear-mode word with mixed bit patterns shows which bit governs which accumulator, including a mode write on the same edge as a strobe.

// File: rtl/dds_phase_pkg.sv
package dds_phase_pkg;
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_ZERO = 1'b1
    } ph_state_t;

    localparam int CLR_W      = 3;
    localparam int CLR_BIT_S1 = 0;
    localparam int CLR_BIT_S2 = 1;
    localparam int CLR_BIT_DC = 2;
endpackage

// File: rtl/dds_clr_mode_reg.sv
module dds_clr_mode_reg
    import dds_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CLR_W-1:0] wdata,
    output logic [CLR_W-1:0] mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode <= '1;
        else if (we)
            mode <= wdata;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mode)); // R3
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mode == $past(wdata)); // R3
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_phase_pkg::*;
#(
    parameter int FREQ_W  = 48,
    parameter int PHASE_W = 16,
    parameter int LANES   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FREQ_W-1:0]  freq,
    input  logic [PHASE_W-1:0] phase,
    input  logic               phase_we,
    input  logic               abs_mode,
    output logic [FREQ_W-1:0]  acc_o,
    output logic [PHASE_W-1:0] offset_o,
    output ph_state_t          state_o
);
    ph_state_t         state_q, state_d;
    logic [FREQ_W-1:0] step;
    logic              abs_hit;

    assign step    = freq * FREQ_W'(LANES);
    assign abs_hit = phase_we && abs_mode;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RUN:  state_d = abs_hit ? PH_ZERO : PH_RUN;
            PH_ZERO: state_d = abs_hit ? PH_ZERO : PH_RUN;
            default: state_d = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_RUN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o    <= '0;
            offset_o <= '0;
        end else begin
            if (state_d == PH_ZERO)
                acc_o <= '0;
            else
                acc_o <= acc_o + step;
            if (phase_we)
                offset_o <= phase;
        end
    end

    assign state_o = state_q;

    AST_ABS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_we && abs_mode) |=> acc_o == '0); // R1
    AST_REL_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_we && !abs_mode) |=> acc_o == $past(acc_o + step)); // R2
    AST_FREE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_we |=> acc_o == $past(acc_o + step)); // R6
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_we |=> $stable(offset_o)); // R10
endmodule

// File: rtl/dds_phase_lanes.sv
module dds_phase_lanes #(
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 16,
    parameter int LANES   = 4
) (
    input  logic [FREQ_W-1:0]        acc,
    input  logic [FREQ_W-1:0]        freq,
    input  logic [PHASE_W-1:0]       offset,
    output logic [LANES*PHASE_W-1:0] phases
);
    localparam int SHIFT = FREQ_W - PHASE_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign phases[k*PHASE_W +: PHASE_W] =
            PHASE_W'((acc + FREQ_W'(k) * freq) >> SHIFT) + offset;
    end
endmodule

// File: rtl/dds_phase_bank.sv
module dds_phase_bank
    import dds_phase_pkg::*;
#(
    parameter int PHASE_W     = 16,
    parameter int SLOW_FREQ_W = 48,
    parameter int DC_FREQ_W   = 32,
    parameter int DC_LANES    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_mode_we,
    input  logic [2:0]                  clr_mode_wdata,
    input  logic [DC_FREQ_W-1:0]        dc_freq,
    input  logic [PHASE_W-1:0]          dc_phase,
    input  logic                        dc_phase_we,
    input  logic [SLOW_FREQ_W-1:0]      s1_freq,
    input  logic [PHASE_W-1:0]          s1_phase,
    input  logic                        s1_phase_we,
    input  logic [SLOW_FREQ_W-1:0]      s2_freq,
    input  logic [PHASE_W-1:0]          s2_phase,
    input  logic                        s2_phase_we,
    output logic [DC_LANES*PHASE_W-1:0] dc_phase_out,
    output logic [PHASE_W-1:0]          s1_phase_out,
    output logic [PHASE_W-1:0]          s2_phase_out
);
    logic [CLR_W-1:0]       mode;
    logic [DC_FREQ_W-1:0]   dc_acc;
    logic [PHASE_W-1:0]     dc_off;
    logic [SLOW_FREQ_W-1:0] s1_acc, s2_acc;
    logic [PHASE_W-1:0]     s1_off, s2_off;
    ph_state_t              dc_st, s1_st, s2_st;

    dds_clr_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (clr_mode_we),
        .wdata (clr_mode_wdata),
        .mode  (mode)
    );

    dds_phase_acc #(.FREQ_W(DC_FREQ_W), .PHASE_W(PHASE_W), .LANES(DC_LANES)) u_dc (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq     (dc_freq),
        .phase    (dc_phase),
        .phase_we (dc_phase_we),
        .abs_mode (mode[CLR_BIT_DC]),
        .acc_o    (dc_acc),
        .offset_o (dc_off),
        .state_o  (dc_st)
    );

    dds_phase_acc #(.FREQ_W(SLOW_FREQ_W), .PHASE_W(PHASE_W), .LANES(1)) u_s1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq     (s1_freq),
        .phase    (s1_phase),
        .phase_we (s1_phase_we),
        .abs_mode (mode[CLR_BIT_S1]),
        .acc_o    (s1_acc),
        .offset_o (s1_off),
        .state_o  (s1_st)
    );

    dds_phase_acc #(.FREQ_W(SLOW_FREQ_W), .PHASE_W(PHASE_W), .LANES(1)) u_s2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq     (s2_freq),
        .phase    (s2_phase),
        .phase_we (s2_phase_we),
        .abs_mode (mode[CLR_BIT_S2]),
        .acc_o    (s2_acc),
        .offset_o (s2_off),
        .state_o  (s2_st)
    );

    dds_phase_lanes #(.FREQ_W(DC_FREQ_W), .PHASE_W(PHASE_W), .LANES(DC_LANES)) u_dc_lanes (
        .acc    (dc_acc),
        .freq   (dc_freq),
        .offset (dc_off),
        .phases (dc_phase_out)
    );

    dds_phase_lanes #(.FREQ_W(SLOW_FREQ_W), .PHASE_W(PHASE_W), .LANES(1)) u_s1_lanes (
        .acc    (s1_acc),
        .freq   (s1_freq),
        .offset (s1_off),
        .phases (s1_phase_out)
    );

    dds_phase_lanes #(.FREQ_W(SLOW_FREQ_W), .PHASE_W(PHASE_W), .LANES(1)) u_s2_lanes (
        .acc    (s2_acc),
        .freq   (s2_freq),
        .offset (s2_off),
        .phases (s2_phase_out)
    );

    AST_S1_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_phase_we && mode[CLR_BIT_S1]) |=> s1_phase_out == $past(s1_phase)); // R1
    AST_S2_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_phase_we && mode[CLR_BIT_S2]) |=> s2_phase_out == $past(s2_phase)); // R1
    AST_DC_LANE0_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_st == PH_ZERO) |-> dc_phase_out[PHASE_W-1:0] == dc_off); // R7
    AST_S1_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_st == PH_ZERO && !s1_phase_we) |=> s1_acc == $past(s1_freq)); // R8
endmodule

// File: tb/dds_phase_bank_test.sv
module dds_phase_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // {mode_we, mode bit0, s1 strobe, s1 phase[15:0], expected s1_phase_out[15:0]}
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 16'h0000, 16'h0001},
        {1'b0, 1'b1, 1'b0, 16'h0000, 16'h0002},
        {1'b0, 1'b1, 1'b1, 16'h0100, 16'h0100},
        {1'b0, 1'b1, 1'b0, 16'h0000, 16'h0101},
        {1'b0, 1'b1, 1'b0, 16'h0000, 16'h0102},
        {1'b1, 1'b0, 1'b0, 16'h0000, 16'h0103},
        {1'b0, 1'b0, 1'b1, 16'h0010, 16'h0014},
        {1'b0, 1'b0, 1'b0, 16'h0000, 16'h0015},
        {1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h0005},
        {1'b1, 1'b1, 1'b1, 16'h0020, 16'h0027},
        {1'b0, 1'b1, 1'b1, 16'h0030, 16'h0030},
        {1'b0, 1'b1, 1'b0, 16'h0000, 16'h0031}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_mode_we = 1'b0;
    logic [2:0]  clr_mode_wdata = 3'b111;
    logic [31:0] dc_freq = '0;
    logic [15:0] dc_phase = '0;
    logic        dc_phase_we = 1'b0;
    logic [47:0] s1_freq = '0;
    logic [15:0] s1_phase = '0;
    logic        s1_phase_we = 1'b0;
    logic [47:0] s2_freq = '0;
    logic [15:0] s2_phase = '0;
    logic        s2_phase_we = 1'b0;
    logic [63:0] dc_phase_out;
    logic [15:0] s1_phase_out, s2_phase_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    dds_phase_bank uut (
        .clk(clk), .rst_n(rst_n),
        .clr_mode_we(clr_mode_we), .clr_mode_wdata(clr_mode_wdata),
        .dc_freq(dc_freq), .dc_phase(dc_phase), .dc_phase_we(dc_phase_we),
        .s1_freq(s1_freq), .s1_phase(s1_phase), .s1_phase_we(s1_phase_we),
        .s2_freq(s2_freq), .s2_phase(s2_phase), .s2_phase_we(s2_phase_we),
        .dc_phase_out(dc_phase_out), .s1_phase_out(s1_phase_out), .s2_phase_out(s2_phase_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] lanes(input logic [15:0] b, input logic [15:0] d);
        return {b + 16'(3*d), b + 16'(2*d), b + d, b};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        clr_mode_we = 1'b0; s1_phase_we = 1'b0; s2_phase_we = 1'b0; dc_phase_we = 1'b0;
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 1'b0;
        tick(); tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // table walk on slow oscillator 1: f = 1<<32, one output count per cycle
        s1_freq = 48'h0001_0000_0000;
        do_reset();
        chk("R4 reset s1 phase", 64'(s1_phase_out), 64'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            clr_mode_we    = VEC[i][34];
            clr_mode_wdata = {2'b11, VEC[i][33]};
            s1_phase_we    = VEC[i][32];
            s1_phase       = VEC[i][31:16];
            tick();
            // R1 absolute, R2 relative, R5 wrap, R8 resume, R9 same-edge mode, R10 hold
            chk($sformatf("R1 R2 R8 R9 R10 vector %0d", i), 64'(s1_phase_out), 64'(VEC[i][15:0]));
        end
        quiet();

        // reset state of all accumulators and clear bits
        s1_freq = 48'h0001_0000_0000;
        s2_freq = 48'h0002_0000_0000;
        dc_freq = 32'h0001_0000;
        do_reset();
        chk("R4 reset dc lanes R7", dc_phase_out, lanes(16'h0, 16'h1));
        chk("R4 reset s2 phase", 64'(s2_phase_out), 64'h0);
        rst_n = 1'b1;
        s1_phase_we = 1'b1; s2_phase_we = 1'b1; dc_phase_we = 1'b1;
        s1_phase = 16'h0011; s2_phase = 16'h0011; dc_phase = 16'h0011;
        tick();
        chk("R4 reset clear bits s1", 64'(s1_phase_out), 64'h11);
        chk("R4 reset clear bits s2", 64'(s2_phase_out), 64'h11);
        chk("R4 reset clear bits dc", dc_phase_out, lanes(16'h11, 16'h1));
        // R3: mode 3'b010 -> only slow 2 absolute
        quiet();
        clr_mode_we = 1'b1; clr_mode_wdata = 3'b010;
        tick();
        chk("R6 dc stride", dc_phase_out, lanes(16'h15, 16'h1));
        quiet();
        s1_phase_we = 1'b1; s2_phase_we = 1'b1; dc_phase_we = 1'b1;
        s1_phase = 16'h0040; s2_phase = 16'h0040; dc_phase = 16'h0040;
        tick();
        chk("R3 bit0 relative s1", 64'(s1_phase_out), 64'h42);
        chk("R3 bit1 absolute s2", 64'(s2_phase_out), 64'h40);
        chk("R3 bit2 relative dc", dc_phase_out, lanes(16'h48, 16'h1));
        quiet();
        clr_mode_we = 1'b1; clr_mode_wdata = 3'b101;
        tick();
        chk("R10 s2 offset held", 64'(s2_phase_out), 64'h42);
        quiet();
        s1_phase_we = 1'b1; s2_phase_we = 1'b1; dc_phase_we = 1'b1;
        s1_phase = 16'h0080; s2_phase = 16'h0080; dc_phase = 16'h0080;
        tick();
        chk("R3 bit0 absolute s1", 64'(s1_phase_out), 64'h80);
        chk("R3 bit1 relative s2", 64'(s2_phase_out), 64'h84);
        chk("R3 R7 bit2 absolute dc lanes", dc_phase_out, lanes(16'h80, 16'h1));
        quiet();
        tick();
        chk("R8 dc resume from zero", dc_phase_out, lanes(16'h84, 16'h1));
        dc_phase_we = 1'b1; dc_phase = 16'h0090;
        tick();
        chk("R1 dc absolute", dc_phase_out, lanes(16'h90, 16'h1));
        tick();
        chk("R8 dc back-to-back absolute", dc_phase_out, lanes(16'h90, 16'h1));
        quiet();

        // wrap and hidden-bit carry
        s1_freq = 48'hFFFF_0000_0000;
        s2_freq = 48'h0000_8000_0000;
        dc_freq = 32'hFFFF_0000;
        do_reset();
        chk("R5 R7 dc negative lanes", dc_phase_out, lanes(16'h0, 16'hFFFF));
        rst_n = 1'b1;
        tick();
        chk("R5 s1 wrap", 64'(s1_phase_out), 64'hFFFF);
        chk("R5 s2 fractional", 64'(s2_phase_out), 64'h0);
        chk("R6 dc wrap stride", dc_phase_out, lanes(16'hFFFC, 16'hFFFF));
        tick();
        chk("R5 s1 wrap second", 64'(s1_phase_out), 64'hFFFE);
        chk("R5 s2 carry", 64'(s2_phase_out), 64'h1);
        finish_run();
    end
endmodule